// File: doc/BRIEF.md
# Shared Word Memory with Atomic Update Windows

This block is a word-organised shared RAM that two masters use to exchange data. Every word is reachable through six address windows of equal size. The plain window gives ordinary loads and stores. A store that lands in one of the other five windows does not overwrite the word. It updates the word in place: add, subtract, bitwise OR, bit clear or bitwise XOR with the stored value. Masters therefore share counters and flag words without any lock protocol.

Each master port is a valid/ready request channel. A request is taken in a cycle where both `pX_valid` and `pX_ready` are high. A master holds its request stable until that happens. Port 0 has fixed priority, so port 1 sees `p1_ready` low in any cycle where port 0 presents a request. An atomic store takes two cycles: the word is read, then written back. In the second cycle both ports see ready low, so no other access can fall between the read and the write. A read returns its data one cycle after acceptance, with a one-cycle `pX_rsp_valid` pulse. The response channel has no back-pressure.

Top module: `smem_atomic`

## Requirements
- R1: After reset, with no requests pending, both ready outputs are high and both response-valid outputs are low.
- R2: A read accepted in cycle N raises that port's rsp_valid in cycle N+1 with the word's current value. A plain store (window code 0, address bits [15:13]=000) replaces the word.
- R3: A store with window code 1 (0x2000 to 0x3FFF) adds the written value to the word, modulo 2^32.
- R4: A store with window code 2 (0x4000 to 0x5FFF) subtracts the written value from the word, modulo 2^32.
- R5: A store with window code 3 (0x6000 to 0x7FFF) ORs the written value into the word.
- R6: A store with window code 4 (0x8000 to 0x9FFF) clears the word's bits that are set in the written value.
- R7: A store with window code 5 (0xA000 to 0xBFFF) XORs the written value into the word.
- R8: The word index is address bits [12:2]. Address bits [1:0] are ignored, and the top word (byte offset 0x1FFC) is reachable.
- R9: A read through any window returns the stored word and leaves it unchanged.
- R10: When both ports request in the same cycle, port 0 is accepted and port 1 is held with ready low until the next cycle. At most one port responds per cycle.
- R11: In the cycle after an atomic store is accepted, both ports see ready low. In the cycle after that, ready is high again.
- R12: Window codes 6 and 7 (0xC000 to 0xFFFF) act as the plain window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_valid | input | 1 | Port 0 request present |
| p0_ready | output | 1 | Port 0 request accepted this cycle if valid |
| p0_write | input | 1 | Port 0 request is a store |
| p0_addr | input | 16 | Port 0 byte address (window code in [15:13]) |
| p0_wdata | input | 32 | Port 0 store value or operand |
| p0_rsp_valid | output | 1 | Port 0 read data valid |
| p0_rdata | output | 32 | Port 0 read data |
| p1_valid | input | 1 | Port 1 request present |
| p1_ready | output | 1 | Port 1 request accepted this cycle if valid |
| p1_write | input | 1 | Port 1 request is a store |
| p1_addr | input | 16 | Port 1 byte address (window code in [15:13]) |
| p1_wdata | input | 32 | Port 1 store value or operand |
| p1_rsp_valid | output | 1 | Port 1 read data valid |
| p1_rdata | output | 32 | Port 1 read data |

## Verification
A wrong window decode or a wrong operation shows up at the next read of the affected word. That read returns a value that differs from the bench's own model, two cycles after the store at the earliest. If the busy state is stuck or missing, the ready pattern in the cycle after an atomic store is wrong, and this is seen within one cycle. If the sequence loses the operand or the word index, a later read of the target word or a neighbouring word returns the wrong data. A wrong priority shows as port 1 being accepted while port 0 waits. It also shows as a response arriving on the wrong port, one cycle after the contested edge.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SET   = 3'd3,
    OP_CLR   = 3'd4,
    OP_XOR   = 3'd5
  } smem_op_e;
endpackage

// File: rtl/smem_alias_decode.sv
module smem_alias_decode
  import smem_pkg::*;
#(
  parameter int IW = 11,
  localparam int AW = IW + 5
) (
  input  logic [AW-1:0] addr,
  output smem_op_e      op,
  output logic [IW-1:0] idx
);
  logic [2:0] win;

  assign win = addr[AW-1 -: 3];
  assign idx = addr[IW+1:2];  // R8: byte offset >> 2

  always_comb begin
    unique case (win)
      3'd1:    op = OP_ADD;
      3'd2:    op = OP_SUB;
      3'd3:    op = OP_SET;
      3'd4:    op = OP_CLR;
      3'd5:    op = OP_XOR;
      default: op = OP_PLAIN;  // R12: codes 6 and 7 fold onto plain
    endcase
  end
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter #(
  parameter int NP = 2
) (
  input  logic [NP-1:0]         req,
  input  logic                  busy,
  output logic [NP-1:0]         rdy,
  output logic                  gnt,
  output logic [$clog2(NP)-1:0] sel
);
  // R10: lower index wins; a port is ready only if no lower port asks
  always_comb begin
    logic blocked;
    blocked = busy;
    gnt     = 1'b0;
    sel     = '0;
    for (int i = 0; i < NP; i++) begin
      rdy[i] = !blocked;
      if (req[i] && !blocked) begin
        gnt = 1'b1;
        sel = i[$clog2(NP)-1:0];
      end
      blocked = blocked | req[i];
    end
  end
endmodule

// File: rtl/smem_rmw_alu.sv
module smem_rmw_alu
  import smem_pkg::*;
(
  input  smem_op_e      op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] new_val
);
  always_comb begin
    unique case (op)
      OP_ADD:  new_val = old_val + opnd;     // R3: wraps
      OP_SUB:  new_val = old_val - opnd;     // R4: wraps
      OP_SET:  new_val = old_val | opnd;     // R5
      OP_CLR:  new_val = old_val & ~opnd;    // R6
      OP_XOR:  new_val = old_val ^ opnd;     // R7
      default: new_val = opnd;
    endcase
  end
endmodule

// File: rtl/smem_ram.sv
module smem_ram #(
  parameter int WORDS = 2048,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/smem_atomic.sv
module smem_atomic
  import smem_pkg::*;
#(
  parameter int WORDS = 2048,
  localparam int AW   = $clog2(WORDS) + 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_valid,
  output logic          p0_ready,
  input  logic          p0_write,
  input  logic [AW-1:0] p0_addr,
  input  logic [31:0]   p0_wdata,
  output logic          p0_rsp_valid,
  output logic [31:0]   p0_rdata,
  input  logic          p1_valid,
  output logic          p1_ready,
  input  logic          p1_write,
  input  logic [AW-1:0] p1_addr,
  input  logic [31:0]   p1_wdata,
  output logic          p1_rsp_valid,
  output logic [31:0]   p1_rdata
);
  localparam int IW = $clog2(WORDS);
  localparam int NP = 2;

  logic [NP-1:0] vld, wr, rdy, acc;
  logic [AW-1:0] adr [NP];
  logic [DW-1:0] wdt [NP];
  smem_op_e      dop [NP];
  logic [IW-1:0] didx [NP];

  assign vld    = {p1_valid, p0_valid};
  assign wr     = {p1_write, p0_write};
  assign adr[0] = p0_addr;
  assign adr[1] = p1_addr;
  assign wdt[0] = p0_wdata;
  assign wdt[1] = p1_wdata;

  for (genvar g = 0; g < NP; g++) begin : g_dec
    smem_alias_decode #(.IW(IW)) u_dec (
      .addr (adr[g]),
      .op   (dop[g]),
      .idx  (didx[g])
    );
  end

  logic busy_q, gnt, sel;

  smem_arbiter #(.NP(NP)) u_arb (
    .req  (vld),
    .busy (busy_q),
    .rdy  (rdy),
    .gnt  (gnt),
    .sel  (sel)
  );

  assign acc      = vld & rdy;
  assign p0_ready = rdy[0];
  assign p1_ready = rdy[1];

  // granted request
  smem_op_e      g_op;
  logic [IW-1:0] g_idx;
  logic [DW-1:0] g_wdata;
  logic          g_wr, g_atomic;

  assign g_op     = dop[sel];
  assign g_idx    = didx[sel];
  assign g_wdata  = wdt[sel];
  assign g_wr     = wr[sel];
  assign g_atomic = gnt && g_wr && (g_op != OP_PLAIN);

  // R11: second cycle of an atomic store holds the operand and target
  smem_op_e      op_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] opnd_q;
  logic [NP-1:0] rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_PLAIN;
      idx_q  <= '0;
      opnd_q <= '0;
      rsp_q  <= '0;
    end else begin
      busy_q <= g_atomic;
      rsp_q  <= acc & ~wr;  // R2: reads answer one cycle later
      if (g_atomic) begin
        op_q   <= g_op;
        idx_q  <= g_idx;
        opnd_q <= g_wdata;
      end
    end
  end

  logic [DW-1:0] ram_rdata, alu_out;
  logic          ram_we;
  logic [IW-1:0] ram_widx;
  logic [DW-1:0] ram_wdata;

  smem_rmw_alu u_alu (
    .op      (op_q),
    .old_val (ram_rdata),
    .opnd    (opnd_q),
    .new_val (alu_out)
  );

  assign ram_we    = busy_q || (gnt && g_wr && (g_op == OP_PLAIN));
  assign ram_widx  = busy_q ? idx_q : g_idx;
  assign ram_wdata = busy_q ? alu_out : g_wdata;

  smem_ram #(.WORDS(WORDS), .DW(DW)) u_ram (
    .clk   (clk),
    .re    (gnt),
    .ridx  (g_idx),
    .rdata (ram_rdata),
    .we    (ram_we),
    .widx  (ram_widx),
    .wdata (ram_wdata)
  );

  assign p0_rsp_valid = rsp_q[0];
  assign p1_rsp_valid = rsp_q[1];
  assign p0_rdata     = ram_rdata;
  assign p1_rdata     = ram_rdata;
endmodule

// File: rtl/smem_atomic_chk.sv
module smem_atomic_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p0_valid,
  input logic          p0_ready,
  input logic          p0_write,
  input logic [AW-1:0] p0_addr,
  input logic          p0_rsp_valid,
  input logic          p1_valid,
  input logic          p1_ready,
  input logic          p1_write,
  input logic [AW-1:0] p1_addr,
  input logic          p1_rsp_valid
);
  logic rd0, rd1, at0, at1;
  assign rd0 = p0_valid && p0_ready && !p0_write;
  assign rd1 = p1_valid && p1_ready && !p1_write;
  assign at0 = p0_valid && p0_ready && p0_write &&
               (p0_addr[AW-1 -: 3] >= 3'd1) && (p0_addr[AW-1 -: 3] <= 3'd5);
  assign at1 = p1_valid && p1_ready && p1_write &&
               (p1_addr[AW-1 -: 3] >= 3'd1) && (p1_addr[AW-1 -: 3] <= 3'd5);

  // R11
  atomic_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at0 || at1) |=> (!p0_ready && !p1_ready));

  // R10
  port0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_valid |-> !p1_ready);

  // R10
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p0_rsp_valid, p1_rsp_valid}));

  // R2
  rsp0_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |=> p0_rsp_valid);

  // R2
  rsp1_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 |=> p1_rsp_valid);

  // R2
  rsp0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_rsp_valid |-> $past(rd0));
endmodule

bind smem_atomic smem_atomic_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .p0_valid     (p0_valid),
  .p0_ready     (p0_ready),
  .p0_write     (p0_write),
  .p0_addr      (p0_addr),
  .p0_rsp_valid (p0_rsp_valid),
  .p1_valid     (p1_valid),
  .p1_ready     (p1_ready),
  .p1_write     (p1_write),
  .p1_addr      (p1_addr),
  .p1_rsp_valid (p1_rsp_valid)
);

// File: tb/sim_smem_atomic.sv
module sim_smem_atomic;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        p0_valid = 0, p0_write = 0, p1_valid = 0, p1_write = 0;
  logic [15:0] p0_addr = 0, p1_addr = 0;
  logic [31:0] p0_wdata = 0, p1_wdata = 0;
  logic        p0_ready, p1_ready, p0_rsp_valid, p1_rsp_valid;
  logic [31:0] p0_rdata, p1_rdata;

  smem_atomic u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [2048];
  logic [31:0] exp_q0 [$], exp_q1 [$];
  string       tag_q0 [$], tag_q1 [$];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (p0_rsp_valid) begin
      if (exp_q0.size() == 0) chk(0, "R2 port0 unexpected rsp", p0_rdata, 0);
      else begin
        logic [31:0] e; string t;
        e = exp_q0.pop_front(); t = tag_q0.pop_front();
        chk(p0_rdata === e, t, p0_rdata, e);
      end
    end
    if (p1_rsp_valid) begin
      if (exp_q1.size() == 0) chk(0, "R10 port1 unexpected rsp", p1_rdata, 0);
      else begin
        logic [31:0] e; string t;
        e = exp_q1.pop_front(); t = tag_q1.pop_front();
        chk(p1_rdata === e, t, p1_rdata, e);
      end
    end
  end

  function automatic void model_update(logic [15:0] a, logic [31:0] d);
    logic [10:0] i;
    i = a[12:2];
    case (a[15:13])
      3'd1: model[i] = model[i] + d;
      3'd2: model[i] = model[i] - d;
      3'd3: model[i] = model[i] | d;
      3'd4: model[i] = model[i] & ~d;
      3'd5: model[i] = model[i] ^ d;
      default: model[i] = d;
    endcase
  endfunction

  // driver: one request on one port, waits for acceptance
  task automatic access(bit p, bit w, logic [15:0] a, logic [31:0] d, string tag);
    bit rdy;
    @(negedge clk);
    if (!p) begin p0_valid = 1; p0_write = w; p0_addr = a; p0_wdata = d; end
    else    begin p1_valid = 1; p1_write = w; p1_addr = a; p1_wdata = d; end
    forever begin
      #1 rdy = p ? p1_ready : p0_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    if (w) model_update(a, d);
    else if (!p) begin exp_q0.push_back(model[a[12:2]]); tag_q0.push_back(tag); end
    else         begin exp_q1.push_back(model[a[12:2]]); tag_q1.push_back(tag); end
    #1;
    if (!p) p0_valid = 0; else p1_valid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(p0_ready && p1_ready && !p0_rsp_valid && !p1_rsp_valid,
        "R1 idle after reset", {p0_ready, p1_ready, p0_rsp_valid, p1_rsp_valid}, 32'hC);

    // R2 plain store and read
    access(0, 1, 16'h0010, 32'hCAFE_0001, "");
    access(0, 0, 16'h0010, 0, "R2 plain read");
    access(1, 1, 16'h0020, 32'h1234_5678, "");
    access(1, 0, 16'h0020, 0, "R2 port1 read");
    // R8 low bits ignored, top word
    access(0, 1, 16'h0033, 32'hA5A5_0000, "");
    access(0, 0, 16'h0030, 0, "R8 low bits ignored");
    access(1, 1, 16'h1FFC, 32'h0BAD_F00D, "");
    access(0, 0, 16'h1FFC, 0, "R8 top word");
    // R3 add wraps
    access(0, 1, 16'h0014, 32'hFFFF_FFF0, "");
    access(0, 1, 16'h2014, 32'h0000_0020, "");
    access(0, 0, 16'h0014, 0, "R3 add wrap");
    // R4 subtract wraps
    access(1, 1, 16'h0018, 32'd3, "");
    access(1, 1, 16'h4018, 32'd5, "");
    access(1, 0, 16'h0018, 0, "R4 sub wrap");
    // R5 R6 R7
    access(0, 1, 16'h001C, 32'h0F0F_0000, "");
    access(0, 1, 16'h601C, 32'h0000_00FF, "");
    access(0, 0, 16'h001C, 0, "R5 set bits");
    access(0, 1, 16'h801C, 32'h0300_00F0, "");
    access(0, 0, 16'h001C, 0, "R6 clear bits");
    access(1, 1, 16'hA01C, 32'hFFFF_0001, "");
    access(1, 0, 16'h001C, 0, "R7 flip bits");
    // R9 alias reads return stored value, no change
    access(0, 0, 16'h2014, 0, "R9 read via add window");
    access(0, 0, 16'hA014, 0, "R9 read via flip window");
    access(0, 0, 16'h0014, 0, "R9 word unchanged");
    // R12 codes 6 and 7 act as plain
    access(0, 1, 16'hC040, 32'h7777_1111, "");
    access(0, 0, 16'h0040, 0, "R12 code 6 store plain");
    access(1, 0, 16'hE040, 0, "R12 code 7 read plain");

    // R11 stall after atomic
    access(0, 1, 16'h2040, 32'd1, "");
    @(negedge clk); #1;
    chk(!p0_ready && !p1_ready, "R11 ready low in second cycle",
        {p0_ready, p1_ready}, 0);
    @(negedge clk); #1;
    chk(p0_ready && p1_ready, "R11 ready back", {p0_ready, p1_ready}, 3);
    access(1, 0, 16'h0040, 0, "R11 atomic result");

    // R10 contention: both read at once
    @(negedge clk);
    p0_valid = 1; p0_write = 0; p0_addr = 16'h0010;
    p1_valid = 1; p1_write = 0; p1_addr = 16'h0020;
    #1;
    chk(p0_ready && !p1_ready, "R10 port0 wins", {p0_ready, p1_ready}, 2);
    exp_q0.push_back(model[4]); tag_q0.push_back("R10 port0 data");
    @(posedge clk); #1 p0_valid = 0;
    @(negedge clk); #1;
    chk(p1_ready, "R10 port1 next cycle", {31'd0, p1_ready}, 1);
    exp_q1.push_back(model[8]); tag_q1.push_back("R10 port1 data");
    @(posedge clk); #1 p1_valid = 0;

    // atomic back-to-back from both ports
    @(negedge clk);
    p0_valid = 1; p0_write = 1; p0_addr = 16'h2050; p0_wdata = 32'd10;
    p1_valid = 1; p1_write = 1; p1_addr = 16'h2050; p1_wdata = 32'd7;
    model[20] = 32'd0;
    access(0, 1, 16'h0050, 32'd0, "");
    p1_valid = 0;
    access(0, 1, 16'h2050, 32'd10, "");
    access(1, 1, 16'h2050, 32'd7, "");
    access(1, 0, 16'h0050, 0, "R3 two atomic adds");

    repeat (4) @(negedge clk);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R2 all reads answered",
        exp_q0.size() + exp_q1.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule